// File: doc/BRIEF.md
# Histogram Counting Sorter for Byte Keys

This block sorts a burst of unsigned byte-wide keys without comparing any two of them. It keeps one occurrence counter for every possible key value in a single on-chip memory. A run has three phases. A clear sweep zeroes every counter. A count phase takes one key per cycle and adds one to that key's counter. An emit phase then walks the counters from the smallest key to the largest and repeats each key on the output as many times as it was counted.

The caller pulses `start` while the block is idle or finished. The caller then waits for `ready`, streams the keys with `in_valid`, and flags the final key with `in_last`. The sorted stream comes back as `out_valid`/`out_key` strobes, and `done` marks the end of the run. Each counter update is a read-modify-write. A one-entry record of the most recent write hides the read-after-write hazard when the same key arrives on consecutive cycles. The run time after the clear sweep depends only on the element count and on how many distinct keys appear.

Top module: `hist_sorter`

## Requirements
- R1: After a synchronous reset, `ready`, `out_valid` and `done` are all low.
- R2: A `start` pulse sampled while idle or done begins a clear sweep of all 256 counters. `ready` first reads high exactly 256 clock edges after the edge that sampled `start`.
- R3: While `ready` is high, every cycle with `in_valid` high counts `in_key` once. A key sampled with `in_last` high ends the count phase, and `ready` is low after that edge. `in_valid` has no effect while `ready` is low.
- R4: One run accepts up to MAX_N keys (default 64). Each counter is ceil(log2(MAX_N+1)) bits wide, so a run of MAX_N identical keys is reproduced in full.
- R5: Identical keys on consecutive cycles are each counted, with no update lost.
- R6: The emit phase presents every accepted key exactly once with `out_valid` high, in non-decreasing key order on `out_key`.
- R7: `done` first reads high exactly 2 + (256 - D) + N edges after the edge that accepted the final key, where N is the number of keys and D the number of distinct keys. Count plus emit therefore take at most 256 + 2N + 2 cycles.
- R8: `done` stays high until the next accepted `start`. `out_valid` is low in every cycle after the first cycle that `done` is high.
- R9: A `start` pulse during the clear, count or emit phases is ignored. The run in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new run (honoured when idle or done) |
| in_valid | input | 1 | Key present on `in_key` this cycle |
| in_key | input | KEY_W | Key to be counted |
| in_last | input | 1 | Marks the final key of the run |
| ready | output | 1 | Count phase active; keys are accepted |
| out_valid | output | 1 | Sorted key present on `out_key` |
| out_key | output | KEY_W | Sorted key output |
| done | output | 1 | Run finished, all keys emitted |

## Verification
The checker watches these properties on every cycle:
- the clear sweep lasts exactly 256 cycles;
- no output strobe overlaps the count phase;
- emitted keys never decrease within a run;
- `done` holds until a new start;
- the number of emitted keys equals the number accepted;
- the emit span stays within its cycle bound.

Other properties need a known stimulus, so only the bench scenarios can show them. These include the exact multiset of the output, the exact emit cycle count for a given number of distinct keys, correct counting of back-to-back identical keys, and the absence of any effect from stray `in_valid` or `start` pulses. The bench shows them with random, all-equal, extreme-value and fully distinct key sets.

// File: rtl/hsort_pkg.sv
package hsort_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_COUNT,
    ST_DRAIN,
    ST_PRIME,
    ST_EMIT,
    ST_DONE
  } state_t;
endpackage

// File: rtl/hsort_bin_ram.sv
// Simple dual-port counter memory: one synchronous write port, one
// registered read port (read-during-write returns the old value).
module hsort_bin_ram #(
  parameter int AW = 8,
  parameter int DW = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hsort_count_pipe.sv
// Read-modify-write stage for the count phase. A read is launched when a
// key is accepted; one cycle later the incremented value is written back.
// The last write is remembered so that a read racing it is corrected.
module hsort_count_pipe #(
  parameter int KEY_W = 8,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             accept,
  input  logic [KEY_W-1:0] key,
  input  logic [CNT_W-1:0] rdata,
  output logic             wr_en,
  output logic [KEY_W-1:0] wr_addr,
  output logic [CNT_W-1:0] wr_data
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             s1_v;
  logic [KEY_W-1:0] s1_key;
  logic             lw_v;
  logic [KEY_W-1:0] lw_addr;
  logic [CNT_W-1:0] lw_data;
  logic [CNT_W-1:0] base;

  always_comb begin
    base    = (lw_v && (lw_addr == s1_key)) ? lw_data : rdata;
    wr_data = base + ONE;
    wr_en   = s1_v;
    wr_addr = s1_key;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      s1_v    <= 1'b0;
      s1_key  <= '0;
      lw_v    <= 1'b0;
      lw_addr <= '0;
      lw_data <= '0;
    end else begin
      s1_v   <= accept;
      s1_key <= key;
      if (s1_v) begin
        lw_v    <= 1'b1;
        lw_addr <= s1_key;
        lw_data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/hsort_emit_walker.sv
// Walks the counters in ascending order. The next counter is always
// prefetched, so an empty bin costs one cycle and the final copy of a
// key is emitted in the same cycle that the walk moves on.
module hsort_emit_walker #(
  parameter int KEY_W = 8,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             prime,
  input  logic             run,
  input  logic [CNT_W-1:0] rdata,
  output logic [KEY_W-1:0] rd_addr,
  output logic             finish,
  output logic             out_valid,
  output logic [KEY_W-1:0] out_key
);
  localparam logic [KEY_W-1:0] KONE  = {{(KEY_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] CONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [KEY_W-1:0] LASTB = '1;

  logic [KEY_W-1:0] cur_bin;
  logic [CNT_W-1:0] wc;
  logic             fresh;
  logic [CNT_W-1:0] cnt;
  logic             adv;
  logic             emit_now;

  always_comb begin
    cnt      = fresh ? rdata : wc;
    emit_now = run && (cnt != '0);
    adv      = run && ((cnt == '0) || (cnt == CONE));
    finish   = adv && (cur_bin == LASTB);
    rd_addr  = prime ? '0 : (cur_bin + KONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_bin   <= '0;
      wc        <= '0;
      fresh     <= 1'b0;
      out_valid <= 1'b0;
      out_key   <= '0;
    end else begin
      out_valid <= emit_now;
      if (emit_now) out_key <= cur_bin;
      if (prime) begin
        cur_bin <= '0;
        fresh   <= 1'b1;
      end else if (run) begin
        if (adv) begin
          cur_bin <= cur_bin + KONE;
          fresh   <= 1'b1;
        end else begin
          fresh <= 1'b0;
          wc    <= cnt - CONE;
        end
      end
    end
  end
endmodule

// File: rtl/hist_sorter.sv
module hist_sorter import hsort_pkg::*; #(
  parameter int KEY_W = 8,
  parameter int MAX_N = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             in_valid,
  input  logic [KEY_W-1:0] in_key,
  input  logic             in_last,
  output logic             ready,
  output logic             out_valid,
  output logic [KEY_W-1:0] out_key,
  output logic             done
);
  localparam int CNT_W = $clog2(MAX_N + 1);
  localparam logic [KEY_W-1:0] KONE  = {{(KEY_W-1){1'b0}}, 1'b1};
  localparam logic [KEY_W-1:0] LASTB = '1;

  state_t           state;
  state_t           state_nx;
  logic [KEY_W-1:0] clr_addr;
  logic             kick;
  logic             accept;
  logic             walk_finish;

  logic             mem_we;
  logic [KEY_W-1:0] mem_waddr;
  logic [CNT_W-1:0] mem_wdata;
  logic [KEY_W-1:0] mem_raddr;
  logic [CNT_W-1:0] mem_rdata;

  logic             cp_we;
  logic [KEY_W-1:0] cp_waddr;
  logic [CNT_W-1:0] cp_wdata;
  logic [KEY_W-1:0] walk_raddr;

  assign kick   = start && ((state == ST_IDLE) || (state == ST_DONE));
  assign accept = in_valid && (state == ST_COUNT);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE, ST_DONE: if (kick) state_nx = ST_CLEAR;
      ST_CLEAR:         if (clr_addr == LASTB) state_nx = ST_COUNT;
      ST_COUNT:         if (accept && in_last) state_nx = ST_DRAIN;
      ST_DRAIN:         state_nx = ST_PRIME;
      ST_PRIME:         state_nx = ST_EMIT;
      ST_EMIT:          if (walk_finish) state_nx = ST_DONE;
      default:          state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      clr_addr <= '0;
    end else begin
      state <= state_nx;
      if (kick) clr_addr <= '0;
      else if (state == ST_CLEAR) clr_addr <= clr_addr + KONE;
    end
  end

  always_comb begin
    if (state == ST_CLEAR) begin
      mem_we    = 1'b1;
      mem_waddr = clr_addr;
      mem_wdata = '0;
    end else begin
      mem_we    = cp_we;
      mem_waddr = cp_waddr;
      mem_wdata = cp_wdata;
    end
    mem_raddr = (state == ST_COUNT) ? in_key : walk_raddr;
  end

  hsort_bin_ram #(.AW(KEY_W), .DW(CNT_W)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  hsort_count_pipe #(.KEY_W(KEY_W), .CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .flush   (kick),
    .accept  (accept),
    .key     (in_key),
    .rdata   (mem_rdata),
    .wr_en   (cp_we),
    .wr_addr (cp_waddr),
    .wr_data (cp_wdata)
  );

  hsort_emit_walker #(.KEY_W(KEY_W), .CNT_W(CNT_W)) u_walk (
    .clk       (clk),
    .rst       (rst),
    .prime     (state == ST_PRIME),
    .run       (state == ST_EMIT),
    .rdata     (mem_rdata),
    .rd_addr   (walk_raddr),
    .finish    (walk_finish),
    .out_valid (out_valid),
    .out_key   (out_key)
  );

  assign ready = (state == ST_COUNT);
  assign done  = (state == ST_DONE);
endmodule

// File: rtl/hsort_checker.sv
module hsort_checker import hsort_pkg::*; #(
  parameter int KEY_W = 8,
  parameter int MAX_N = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             in_valid,
  input logic             ready,
  input logic             out_valid,
  input logic [KEY_W-1:0] out_key,
  input logic             done,
  input state_t           state
);
  localparam int CNT_W = $clog2(MAX_N + 1);
  localparam int BINS  = 1 << KEY_W;

  logic             kick;
  logic [15:0]      clr_cnt;
  logic [15:0]      acc_cnt;
  logic [15:0]      emit_cnt;
  logic [15:0]      emit_cyc;
  logic [KEY_W-1:0] last_key;
  logic             seen;

  assign kick = start && ((state == ST_IDLE) || (state == ST_DONE));

  always_ff @(posedge clk) begin
    if (rst || kick) begin
      clr_cnt  <= '0;
      acc_cnt  <= '0;
      emit_cnt <= '0;
      emit_cyc <= '0;
      last_key <= '0;
      seen     <= 1'b0;
    end else begin
      if (state == ST_CLEAR) clr_cnt <= clr_cnt + 16'd1;
      if (ready && in_valid) acc_cnt <= acc_cnt + 16'd1;
      if (out_valid) begin
        emit_cnt <= emit_cnt + 16'd1;
        last_key <= out_key;
        seen     <= 1'b1;
      end
      if ((state == ST_DRAIN) || (state == ST_PRIME) || (state == ST_EMIT))
        emit_cyc <= emit_cyc + 16'd1;
    end
  end

  AST_CLEAR_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (int'(clr_cnt) == BINS)); // R2

  AST_NO_OUT_IN_COUNT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !ready); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (ready && in_valid) |-> (int'(acc_cnt) < MAX_N)); // R4

  AST_KEYS_ASCEND: assert property (@(posedge clk) disable iff (rst)
    (out_valid && seen) |-> (out_key >= last_key)); // R6

  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (rst)
    ($rose(done) && !start) |=> (emit_cnt == acc_cnt)); // R6

  AST_EMIT_BUDGET: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (int'(emit_cyc) <= BINS + int'(acc_cnt) + 2)); // R7

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done); // R8

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done)) |-> !out_valid); // R8

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && (state == ST_EMIT)) |=> (state != ST_CLEAR)); // R9

  initial assert (CNT_W >= 1); // R4
endmodule

bind hist_sorter hsort_checker #(.KEY_W(KEY_W), .MAX_N(MAX_N)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .in_valid  (in_valid),
  .ready     (ready),
  .out_valid (out_valid),
  .out_key   (out_key),
  .done      (done),
  .state     (state)
);

// File: tb/hist_sorter_tb.sv
`timescale 1ns/1ps
module hist_sorter_tb;
  localparam int KEY_W = 8;
  localparam int MAX_N = 64;
  localparam int BINS  = 256;

  logic             clk = 1'b0;
  logic             rst;
  logic             start;
  logic             in_valid;
  logic [KEY_W-1:0] in_key;
  logic             in_last;
  logic             ready;
  logic             out_valid;
  logic [KEY_W-1:0] out_key;
  logic             done;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  logic [7:0] kq [0:MAX_N-1];
  int         got_k [0:MAX_N-1];
  int         exp_k [0:MAX_N-1];

  always #10 clk = ~clk;

  hist_sorter #(.KEY_W(KEY_W), .MAX_N(MAX_N)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .in_valid  (in_valid),
    .in_key    (in_key),
    .in_last   (in_last),
    .ready     (ready),
    .out_valid (out_valid),
    .out_key   (out_key),
    .done      (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_sort(input int n, input bit gaps, input bit poke, input string tag);
    int hist [0:BINS-1];
    int distinct;
    int ne;
    int j;
    int got;
    int e;
    for (int b = 0; b < BINS; b++) hist[b] = 0;
    for (int i = 0; i < n; i++) hist[kq[i]]++;
    distinct = 0;
    e = 0;
    for (int b = 0; b < BINS; b++) begin
      if (hist[b] != 0) distinct++;
      for (int c = 0; c < hist[b]; c++) begin
        exp_k[e] = b;
        e++;
      end
    end

    // start, with stray keys offered during the clear sweep (R3)
    @(negedge clk);
    start = 1'b1; in_valid = 1'b1; in_key = 8'h55; in_last = 1'b0;
    @(negedge clk);
    start = 1'b0;
    ne = 0;
    while (!ready && ne < 1000) begin
      @(negedge clk);
      ne++;
    end
    chk(ne == BINS, {"R2 clear length ", tag}, ne, BINS);

    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 3 == 1)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_key   = kq[i];
      in_last  = (i == n - 1);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    chk(ready == 1'b0, {"R3 ready drops after last ", tag}, ready, 0);

    j = 0;
    got = 0;
    while (j < 2000) begin
      @(negedge clk);
      j++;
      if (j == 3) begin in_valid = 1'b1; in_key = 8'h00; end  // R3 ignored
      if (j == 4) in_valid = 1'b0;
      if (poke && j == 5) start = 1'b1;                       // R9 ignored
      if (poke && j == 6) start = 1'b0;
      if (out_valid) begin
        if (got < MAX_N) got_k[got] = int'(out_key);
        got++;
      end
      if (done) break;
    end
    chk(j == 258 - distinct + n, {"R7 done latency ", tag}, j, 258 - distinct + n);
    chk(got == n, {"R6 output count ", tag}, got, n);
    for (int i = 0; i < n && i < got; i++)
      chk(got_k[i] == exp_k[i], {"R6 sorted key ", tag}, got_k[i], exp_k[i]);

    @(negedge clk);
    chk(done == 1'b1, {"R8 done held ", tag}, done, 1);
    chk(out_valid == 1'b0, {"R8 quiet after done ", tag}, out_valid, 0);
    repeat (3) @(negedge clk);
    chk(done == 1'b1, {"R8 done still held ", tag}, done, 1);
  endtask

  initial begin
    int unsigned seed;
    rst = 1'b1; start = 1'b0; in_valid = 1'b0; in_key = '0; in_last = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ready == 1'b0, "R1 ready after reset", ready, 0);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(done == 1'b0, "R1 done after reset", done, 0);

    // pseudo-random keys with input gaps and a start pulse during emit
    seed = 32'd12345;
    for (int i = 0; i < 20; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      kq[i] = seed[23:16];
    end
    run_sort(20, 1'b1, 1'b1, "random20");

    // MAX_N identical keys back to back (R4, R5)
    for (int i = 0; i < MAX_N; i++) kq[i] = 8'hA7;
    run_sort(MAX_N, 1'b0, 1'b0, "R4_R5 all-equal");

    // runs of equal keys at the extreme values (R5)
    for (int i = 0; i < 12; i++)
      kq[i] = (i % 4 < 2) ? 8'h00 : ((i % 4 == 2) ? 8'hFF : 8'h01);
    run_sort(12, 1'b0, 1'b0, "R5 extremes");

    // single element at the top key
    kq[0] = 8'hFF;
    run_sort(1, 1'b0, 1'b0, "single");

    // MAX_N distinct keys in descending order
    for (int i = 0; i < MAX_N; i++) kq[i] = 8'(255 - i * 3);
    run_sort(MAX_N, 1'b1, 1'b1, "descending");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule